// File: doc/BRIEF.md
# Sample-and-Convert Successive-Approximation Sequencer

This block runs one analog-to-digital conversion each time the host finishes a write cycle to the module. When the write ends, it drives a sample-and-hold pulse of a fixed length, counted in master-clock cycles. It then drives a one-cycle active-low start strobe. After that it performs a twelve-step binary search. At every step it presents a trial code to an external DAC and reads back a single comparator decision. The decision is taken on a step clock that is the bus master clock divided by a parameter (25 by default).

The analog parts (DAC, comparator, sample-and-hold) stay outside the block and are represented only by their digital signals. The block reports progress with a busy flag and an active-low end-of-conversion line. It keeps the finished code on a result output until the next conversion completes. A synchronous reset returns it to idle.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts on the trailing edge of a write: the cycle after `wr_n`/`cs_n` stop being both low, `busy` and `sh_pulse` are high. Nothing starts while the write is still held.
- R2: A `wr_n` pulse with `cs_n` high does not start a conversion.
- R3: `sh_pulse` stays high for exactly `SH_CYCLES` master-clock cycles (default 150).
- R4: `start_n` is low for exactly one cycle, the cycle right after `sh_pulse` falls.
- R5: Each step lasts `DIV` master cycles. `eoc_n` falls exactly `1 + WIDTH*DIV` cycles after the cycle in which `start_n` is low (301 with the defaults).
- R6: Bits are decided from the MSB down. In the first step `trial_code` is `12'h800`. In every step the bit under test is 1 and all lower bits are 0.
- R7: At each step, `cmp_n` low keeps the trial bit at 1 and `cmp_n` high clears it to 0. `result` is the code built from the twelve decisions.
- R8: `eoc_n` falls, and `busy` falls, on the same edge that records the last bit. `result` is valid from that edge.
- R9: `busy` is high from the trigger until end of conversion and never overlaps low `eoc_n`. A write that ends while busy is ignored: it gives no new sample pulse and does not change the timing or the result.
- R10: `eoc_n` returns high on the trigger of the next conversion. `result` holds its value until that conversion finishes.
- R11: A synchronous reset sets `busy`=0, `eoc_n`=1, `sh_pulse`=0, `start_n`=1, `trial_code`=0 and `result`=0, even in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Host write strobe, active low |
| cs_n | input | 1 | Module select, active low |
| cmp_n | input | 1 | Comparator decision, low = keep trial bit |
| trial_code | output | 12 | Code driven to the external DAC |
| result | output | 12 | Last completed conversion |
| busy | output | 1 | Conversion in progress |
| sh_pulse | output | 1 | Sample-and-hold control, high = sample |
| start_n | output | 1 | One-cycle start strobe, active low |
| eoc_n | output | 1 | End of conversion, active low |

## Verification
On every cycle, the assertions check how the control outputs are ordered with respect to each other:
- `busy` and low `eoc_n` never coexist;
- the start strobe is one cycle long and follows the end of the sample pulse;
- a sample pulse only begins from idle;
- the lower bits of the trial code are clear during a step.

Some properties only the bench scenarios can show. These are the exact pulse and conversion lengths, that the result matches an input level across several codes (both ends of the range and the mid-scale edge), that a write without select or during a conversion has no effect, and that a reset in mid-conversion recovers cleanly.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_START  = 2'd2,
    ST_STEP   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_wr_edge.sv
module sar_wr_edge (
  input  logic clk,
  input  logic rst,
  input  logic wr_n,
  input  logic cs_n,
  output logic wr_done
);
  logic wr_act;
  logic wr_act_q;

  assign wr_act = !wr_n && !cs_n;

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_act;
  end

  // trailing edge of a selected write
  assign wr_done = wr_act_q && !wr_act;
endmodule

// File: rtl/sar_step_div.sv
module sar_step_div #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1 && tick) |=> !tick); // R5
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int WIDTH     = 12,
  parameter int SH_CYCLES = 150
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             tick,
  input  logic             cmp_n,
  output logic             div_clr,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] result,
  output logic             busy,
  output logic             sh_pulse,
  output logic             start_n,
  output logic             eoc_n
);
  localparam int IW  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int SHW = $clog2(SH_CYCLES + 1);

  sar_state_e       state;
  logic [SHW-1:0]   sh_cnt;
  logic [IW-1:0]    bit_idx;
  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] result_q;
  logic             busy_q;
  logic             eoc_n_q;

  // record the decision for bit idx, then raise the next lower bit for trial
  function automatic logic [WIDTH-1:0] apply_decision(
    input logic [WIDTH-1:0] code, input logic [IW-1:0] idx, input logic keep);
    logic [WIDTH-1:0] nxt;
    nxt = code;
    nxt[idx] = keep;
    if (idx != '0) nxt[idx - IW'(1)] = 1'b1;
    return nxt;
  endfunction

  function automatic logic [WIDTH-1:0] low_mask(input logic [IW-1:0] idx);
    return (WIDTH'(1) << idx) - WIDTH'(1);
  endfunction

  // named internal events
  logic             sh_last;
  logic             last_step;
  logic             step_decide;
  logic [WIDTH-1:0] decided;

  assign sh_last     = (sh_cnt == SHW'(SH_CYCLES - 1));
  assign last_step   = (bit_idx == '0);
  assign step_decide = (state == ST_STEP) && tick;
  assign decided     = apply_decision(code_q, bit_idx, !cmp_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sh_cnt   <= '0;
      bit_idx  <= '0;
      code_q   <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
      eoc_n_q  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (trig) begin
          state   <= ST_SAMPLE;
          sh_cnt  <= '0;
          busy_q  <= 1'b1;
          eoc_n_q <= 1'b1;
        end
        ST_SAMPLE: begin
          if (sh_last) state <= ST_START;
          else         sh_cnt <= sh_cnt + SHW'(1);
        end
        ST_START: begin
          state   <= ST_STEP;
          bit_idx <= IW'(WIDTH - 1);
          code_q  <= WIDTH'(1) << (WIDTH - 1);
        end
        ST_STEP: if (step_decide) begin
          if (last_step) begin
            result_q <= decided;
            code_q   <= '0;
            busy_q   <= 1'b0;
            eoc_n_q  <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            code_q  <= decided;
            bit_idx <= bit_idx - IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign div_clr    = (state != ST_STEP);
  assign trial_code = code_q;
  assign result     = result_q;
  assign busy       = busy_q;
  assign sh_pulse   = (state == ST_SAMPLE);
  assign start_n    = (state != ST_START);
  assign eoc_n      = eoc_n_q;

  AST_BUSY_EOC_EXCL: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> eoc_n_q); // R9
  AST_SH_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sh_pulse) |-> !$past(busy_q)); // R9
  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (rst)
    (trig && !busy_q) |=> (busy_q && sh_pulse && eoc_n_q)); // R1
  AST_START_AFTER_SH: assert property (@(posedge clk) disable iff (rst)
    $fell(sh_pulse) |-> !start_n); // R4
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !start_n |=> start_n); // R4
  AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STEP) |-> (code_q[bit_idx] && ((code_q & low_mask(bit_idx)) == '0))); // R6
  AST_EOC_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n_q) |-> ($past(busy_q) && !busy_q)); // R8
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int WIDTH     = 12,
  parameter int DIV       = 25,
  parameter int SH_CYCLES = 150
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             cs_n,
  input  logic             cmp_n,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] result,
  output logic             busy,
  output logic             sh_pulse,
  output logic             start_n,
  output logic             eoc_n
);
  logic trig;
  logic tick;
  logic div_clr;

  sar_wr_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .wr_n    (wr_n),
    .cs_n    (cs_n),
    .wr_done (trig)
  );

  sar_step_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (div_clr),
    .tick (tick)
  );

  sar_engine #(.WIDTH(WIDTH), .SH_CYCLES(SH_CYCLES)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .tick       (tick),
    .cmp_n      (cmp_n),
    .div_clr    (div_clr),
    .trial_code (trial_code),
    .result     (result),
    .busy       (busy),
    .sh_pulse   (sh_pulse),
    .start_n    (start_n),
    .eoc_n      (eoc_n)
  );
endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;
  localparam int W     = 12;
  localparam int DIVB  = 25;
  localparam int SHB   = 150;
  localparam int CONVT = 1 + W * DIVB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1;
  logic cs_n = 1'b1;
  logic [W-1:0] level = '0;
  logic [W-1:0] trial_code, result;
  logic busy, sh_pulse, start_n, eoc_n;
  logic cmp_n;

  // comparator model: keep the bit while the trial does not exceed the level
  assign cmp_n = (trial_code > level);

  always #2.5 clk = ~clk;

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .cmp_n(cmp_n),
    .trial_code(trial_code), .result(result), .busy(busy),
    .sh_pulse(sh_pulse), .start_n(start_n), .eoc_n(eoc_n)
  );

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int sh_rises = 0;
  int done_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  bit prev_sh = 0, prev_eoc = 1, armed = 0, first_pending = 0;
  int sh_len = 0, cyc = 0, start_len = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_sh = 0; prev_eoc = 1; armed = 0; first_pending = 0;
      sh_len = 0; cyc = 0; start_len = 0;
    end else begin
      if (first_pending) begin
        check(trial_code == 12'h800, "R6 first trial", trial_code, 12'h800);
        first_pending = 0;
      end
      if (sh_pulse && !prev_sh) sh_rises++;
      if (sh_pulse) sh_len++;
      if (!sh_pulse && prev_sh) begin
        check(sh_len == SHB, "R3 sample width", sh_len, SHB);
        check(start_n == 1'b0, "R4 start after sample", start_n, 0);
        sh_len = 0;
      end
      if (armed) cyc++;
      if (!start_n) begin
        start_len++; armed = 1; cyc = 0; first_pending = 1;
      end else if (start_len != 0) begin
        check(start_len == 1, "R4 start length", start_len, 1);
        start_len = 0;
      end
      if (!eoc_n && prev_eoc) begin
        int e;
        done_cnt++;
        check(armed && cyc == CONVT, "R5 conversion time", cyc, CONVT);
        check(busy == 1'b0, "R8 busy drops with eoc", busy, 0);
        armed = 0;
        if (exp_q.size() == 0) check(0, "R7 unexpected result", result, 0);
        else begin
          e = exp_q.pop_front();
          check(result == W'(e), "R7 result", result, e);
        end
      end
      prev_sh = sh_pulse;
      prev_eoc = eoc_n;
    end
  end

  task automatic write_pulse(input bit sel, input int len);
    @(negedge clk);
    wr_n = 1'b0; cs_n = sel ? 1'b0 : 1'b1;
    repeat (len) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while (!(eoc_n == 1'b0 && busy == 1'b0) && n < 2000);
    @(negedge clk);
  endtask

  task automatic convert(input logic [W-1:0] v);
    level = v;
    exp_q.push_back(int'(v));
    write_pulse(1'b1, 3);
    wait_done();
    check(exp_q.size() == 0, "R7 result delivered", exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rises0;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, sh_pulse, start_n, eoc_n} == 4'b0011, "R11 reset controls",
          {busy, sh_pulse, start_n, eoc_n}, 4'b0011);
    check(trial_code == 0 && result == 0, "R11 reset codes", result, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 write without select
    write_pulse(1'b0, 5);
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && sh_rises == 0, "R2 unselected write ignored", busy, 0);

    // R1 trailing-edge trigger
    level = 12'hA5C;
    exp_q.push_back(12'hA5C);
    @(negedge clk); wr_n = 1'b0; cs_n = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && sh_pulse == 1'b0, "R1 no start while write held", busy, 0);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b1 && sh_pulse == 1'b1, "R1 start after write ends", {busy, sh_pulse}, 2'b11);
    wait_done();

    // R7 several levels
    convert(12'hFFF);
    convert(12'h000);
    convert(12'h001);
    convert(12'h800);
    convert(12'h7FF);

    // R10 result holds, eoc returns high on new trigger
    held = result;
    repeat (50) @(negedge clk);
    check(result == held && eoc_n == 1'b0, "R10 result held while idle", result, held);
    level = 12'h3C3;
    exp_q.push_back(12'h3C3);
    write_pulse(1'b1, 2);
    @(negedge clk);
    check(eoc_n == 1'b1 && busy == 1'b1, "R10 eoc high on new trigger", eoc_n, 1);
    check(result == held, "R10 result kept during conversion", result, held);
    wait_done();

    // R9 write during conversion ignored
    rises0 = sh_rises;
    level = 12'h123;
    exp_q.push_back(12'h123);
    write_pulse(1'b1, 2);
    repeat (200) @(negedge clk);
    write_pulse(1'b1, 2);
    wait_done();
    repeat (20) @(negedge clk);
    check(sh_rises == rises0 + 1, "R9 retrigger ignored", sh_rises - rises0, 1);
    check(busy == 1'b0 && eoc_n == 1'b0, "R9 idle after single conversion", busy, 0);

    // R11 reset mid-conversion
    level = 12'h555;
    exp_q.push_back(12'h555);
    write_pulse(1'b1, 2);
    repeat (250) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    exp_q.delete();
    check({busy, sh_pulse, start_n, eoc_n} == 4'b0011, "R11 mid-conversion reset controls",
          {busy, sh_pulse, start_n, eoc_n}, 4'b0011);
    check(trial_code == 0 && result == 0, "R11 mid-conversion reset codes", trial_code, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    convert(12'h9E1);

    check(done_cnt == 9, "R8 completed conversions", done_cnt, 9);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule